// File: doc/BRIEF.md
# Indirect Register Access Bridge

This bridge lets a host reach a private register space through a small window of directly mapped registers. The host first loads a target address, and for a write also the data. It then sets a command bit, polls a completion flag and finally writes zero to the command register. The bridge turns each accepted command into a single transaction on an internal register port. That port has a one-cycle request pulse and waits for the target's ready signal.

The window has six locations selected by a 3-bit host offset. Offset 0 holds the target address. Offset 1 holds the write data. Offset 2 holds the read result and is read-only. Offset 3 is the command register. Offset 4 is the done flag and is read-only. Offset 5 is the timeout error flag and is read-only. The host port is a valid/ready register port that accepts every access. Read data comes back one cycle after the read is accepted, marked by a return strobe.

An access that gets no ready within a programmable number of cycles is abandoned. In that case the error flag is raised and the done flag stays low, so a polling host never takes an unfinished access for a finished one.

Top module: `ireg_window_bridge`

## Requirements
- R1: After reset every window location reads zero. Offsets 0 (address) and 1 (write data) read back the last value written to them. Read data appears with `host_rvalid` one cycle after the read is accepted.
- R2: Writing a value whose bit 31 rises and whose bit 30 is clear starts a write. In the cycle after the command write is accepted, `int_req` is high for exactly one cycle, with `int_we`=1 and the address and write-data registers on `int_addr`/`int_wdata`.
- R3: Writing a value whose bit 30 rises and whose bit 31 is clear starts a read with `int_we`=0. The target's `int_rdata` in the ready cycle is latched into offset 2.
- R4: Offset 4 reads 0 while an access is pending and reads 1 after the target has signalled ready for it.
- R5: Writing zero to the command register (offset 3) clears the done and error flags. The read-data register keeps its value.
- R6: A command value with both bits 31 and 30 set, or with neither set, starts no access.
- R7: Writing the command register again with a command bit that is already set does not start a new access.
- R8: If no ready arrives within `TIMEOUT_CYC` cycles of the request, the access ends, offset 5 reads 1 and offset 4 stays 0.
- R9: While an access is pending, command writes start no further request.
- R10: Writes to offsets 2 and 4 have no effect on what those offsets read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Window offset |
| host_wdata | input | DATA_W | Host write data |
| host_ready | output | 1 | Access accepted (always high) |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | DATA_W | Read data |
| int_req | output | 1 | One-cycle internal request |
| int_we | output | 1 | Internal write enable |
| int_addr | output | ADDR_W | Internal target address |
| int_wdata | output | DATA_W | Internal write data |
| int_rdata | input | DATA_W | Internal read data |
| int_ready | input | 1 | Target completion |

## Verification
A command write accepted at a clock edge raises `int_req` in the cycle after that edge. The bench therefore samples the request fields at the falling edge right after its command-write task returns. A window read is answered one cycle after acceptance, so the scoreboard monitor pops the expected value on the falling edge where `host_rvalid` is high. The done and error flags move one edge after ready or after the `TIMEOUT_CYC`-th waiting cycle, so the bench reads them by bounded polling or after a wait counted well clear of that edge. The single pending-state check is placed two cycles before the target model answers.

// File: rtl/ireg_pkg.sv
// Shared types for the indirect register access bridge.
package ireg_pkg;

    // Window offsets seen by the host
    typedef enum logic [2:0] {
        WIN_ADDR  = 3'd0,
        WIN_WDATA = 3'd1,
        WIN_RDATA = 3'd2,
        WIN_CMD   = 3'd3,
        WIN_DONE  = 3'd4,
        WIN_ERR   = 3'd5
    } win_sel_e;

    // Sequencer states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } acc_state_e;

endpackage

// File: rtl/ireg_win_regs.sv
// Host-visible window registers.
// Holds the address, write-data, read-data and command registers and
// answers host reads one cycle after acceptance.
// Assumes ADDR_W < DATA_W. Done/error flags come from the sequencer.
module ireg_win_regs
    import ireg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_value,
    input  logic              done_flag,
    input  logic              err_flag,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic              cmd_wr
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] rdata_q;
    logic              wr_en;
    logic              rd_en;

    assign wr_en  = host_valid && host_write;
    assign rd_en  = host_valid && !host_write;
    assign cmd_wr = wr_en && (host_addr == WIN_CMD);

    // Writable registers: address, write data, command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr  <= '0;
            tgt_wdata <= '0;
            cmd_q     <= '0;
        end else if (wr_en) begin
            case (host_addr)
                WIN_ADDR:  tgt_addr  <= host_wdata[ADDR_W-1:0];
                WIN_WDATA: tgt_wdata <= host_wdata;
                WIN_CMD:   cmd_q     <= host_wdata;
                default:   ;
            endcase
        end
    end

    // Read-result register, loaded only by a completing read
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_load) rdata_q <= rd_value;
    end

    // Registered host read path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= rd_en;
            if (rd_en) begin
                case (host_addr)
                    WIN_ADDR:  host_rdata <= {{PAD_W{1'b0}}, tgt_addr};
                    WIN_WDATA: host_rdata <= tgt_wdata;
                    WIN_RDATA: host_rdata <= rdata_q;
                    WIN_CMD:   host_rdata <= cmd_q;
                    WIN_DONE:  host_rdata <= {{(DATA_W-1){1'b0}}, done_flag};
                    WIN_ERR:   host_rdata <= {{(DATA_W-1){1'b0}}, err_flag};
                    default:   host_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ireg_cmd_trigger.sv
// Command decode.
// Turns a host write to the command register into a start-write,
// start-read or clear event. A start needs exactly one command bit set,
// that bit newly rising, and an idle sequencer.
module ireg_cmd_trigger #(
    parameter int DATA_W = 32
) (
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_new,
    input  logic [1:0]        cmd_old_bits,
    input  logic              busy,
    output logic              go_write,
    output logic              go_read,
    output logic              clr
);
    localparam int WR_BIT = DATA_W - 1;
    localparam int RD_BIT = DATA_W - 2;

    logic wr_code;
    logic rd_code;

    // Single-code decode with rising-edge qualification
    always_comb begin
        wr_code  = cmd_new[WR_BIT] && !cmd_new[RD_BIT];
        rd_code  = cmd_new[RD_BIT] && !cmd_new[WR_BIT];
        go_write = cmd_wr && !busy && wr_code && !cmd_old_bits[1];
        go_read  = cmd_wr && !busy && rd_code && !cmd_old_bits[0];
        clr      = cmd_wr && (cmd_new == '0);
    end
endmodule

// File: rtl/ireg_wait_timer.sv
// Timeout counter for a pending internal access.
// Counts waiting cycles and flags expiry in the LIMIT-th one.
module ireg_wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count cycles spent waiting; restart at each new access
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ireg_access_seq.sv
// Internal access sequencer.
// Issues a one-cycle request and waits for ready or timeout.
// Reports done or error and requests the read-data load.
// Address and data are captured at start, so later window writes do not
// disturb a pending access.
module ireg_access_seq
    import ireg_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 16,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_write,
    input  logic              go_read,
    input  logic              clr,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_wdata,
    input  logic              int_ready,
    output logic              int_req,
    output logic              int_we,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    output logic              busy,
    output logic              done_flag,
    output logic              err_flag,
    output logic              rd_load
);
    acc_state_e state_q;
    logic       start;
    logic       expired;

    assign start   = go_write || go_read;
    assign busy    = (state_q == ST_WAIT);
    assign rd_load = busy && int_ready && !int_we;

    ireg_wait_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .run     (busy && !int_ready),
        .expired (expired)
    );

    // State, request pulse and completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            int_req   <= 1'b0;
            int_we    <= 1'b0;
            int_addr  <= '0;
            int_wdata <= '0;
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            int_req <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q   <= ST_WAIT;
                        int_req   <= 1'b1;
                        int_we    <= go_write;
                        int_addr  <= tgt_addr;
                        int_wdata <= tgt_wdata;
                        done_flag <= 1'b0;
                        err_flag  <= 1'b0;
                    end else if (clr) begin
                        done_flag <= 1'b0;
                        err_flag  <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (int_ready) begin
                        state_q   <= ST_IDLE;
                        done_flag <= 1'b1;
                    end else if (expired) begin
                        state_q  <= ST_IDLE;
                        err_flag <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ireg_window_bridge.sv
// Top of the indirect register access bridge.
// Connects the host window, the command decode and the access sequencer.
// The host port accepts every access (host_ready is constant high).
module ireg_window_bridge #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 16,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              int_req,
    output logic              int_we,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    input  logic [DATA_W-1:0] int_rdata,
    input  logic              int_ready
);
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] tgt_wdata;
    logic [DATA_W-1:0] cmd_q;
    logic              cmd_wr;
    logic              go_write;
    logic              go_read;
    logic              clr;
    logic              busy;
    logic              done_flag;
    logic              err_flag;
    logic              rd_load;

    assign host_ready = 1'b1;

    ireg_win_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_valid  (host_valid),
        .host_write  (host_write),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata),
        .rd_load     (rd_load),
        .rd_value    (int_rdata),
        .done_flag   (done_flag),
        .err_flag    (err_flag),
        .tgt_addr    (tgt_addr),
        .tgt_wdata   (tgt_wdata),
        .cmd_q       (cmd_q),
        .cmd_wr      (cmd_wr)
    );

    ireg_cmd_trigger #(.DATA_W(DATA_W)) i_trig (
        .cmd_wr       (cmd_wr),
        .cmd_new      (host_wdata),
        .cmd_old_bits (cmd_q[DATA_W-1:DATA_W-2]),
        .busy         (busy),
        .go_write     (go_write),
        .go_read      (go_read),
        .clr          (clr)
    );

    ireg_access_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_write  (go_write),
        .go_read   (go_read),
        .clr       (clr),
        .tgt_addr  (tgt_addr),
        .tgt_wdata (tgt_wdata),
        .int_ready (int_ready),
        .int_req   (int_req),
        .int_we    (int_we),
        .int_addr  (int_addr),
        .int_wdata (int_wdata),
        .busy      (busy),
        .done_flag (done_flag),
        .err_flag  (err_flag),
        .rd_load   (rd_load)
    );
endmodule

// File: rtl/ireg_bridge_chk.sv
// Protocol checker for the bridge, attached by bind.
// Watches the request pulse, completion flags and host read return.
module ireg_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic host_valid,
    input logic host_write,
    input logic host_rvalid,
    input logic int_req,
    input logic int_ready,
    input logic busy,
    input logic done_flag,
    input logic err_flag
);
    // R1
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_valid && !host_write));

    // R2
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |=> !int_req);

    // R9
    req_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !$past(busy));

    // R4
    done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(int_ready));

    // R4
    no_done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done_flag);

    // R8
    err_without_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !done_flag);
endmodule

bind ireg_window_bridge ireg_bridge_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_rvalid (host_rvalid),
    .int_req     (int_req),
    .int_ready   (int_ready),
    .busy        (busy),
    .done_flag   (done_flag),
    .err_flag    (err_flag)
);

// File: tb/test_ireg_window_bridge.sv
// Scoreboard bench: host reads push expected values, a monitor compares
// them when the read data returns; a target model answers requests.
module test_ireg_window_bridge;
    localparam int DW   = 32;
    localparam int AW   = 16;
    localparam int TOUT = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_valid = 1'b0;
    logic          host_write = 1'b0;
    logic [2:0]    host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready;
    logic          host_rvalid;
    logic [DW-1:0] host_rdata;
    logic          int_req;
    logic          int_we;
    logic [AW-1:0] int_addr;
    logic [DW-1:0] int_wdata;
    logic [DW-1:0] int_rdata = '0;
    logic          int_ready = 1'b0;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // scoreboard queues
    bit          chk_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_rd;

    // target model state
    logic [31:0] tmem [16];
    bit          tgt_on = 1;
    int          tgt_lat = 0;
    bit          pend = 0;
    int          wcnt = 0;
    logic [3:0]  pend_addr = '0;
    int          req_cnt = 0;

    always #10 clk = ~clk;

    ireg_window_bridge #(.DATA_W(DW), .ADDR_W(AW), .TIMEOUT_CYC(TOUT)) i_ireg_window_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata), .int_req(int_req), .int_we(int_we),
        .int_addr(int_addr), .int_wdata(int_wdata), .int_rdata(int_rdata),
        .int_ready(int_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare returned read data against the queue
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            last_rd = host_rdata;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                bit c;
                string t;
                e = exp_q.pop_front();
                c = chk_q.pop_front();
                t = tag_q.pop_front();
                if (c) check(t, host_rdata, e);
            end
        end
    end

    // target model: latency-programmable ready, small backing store
    always @(negedge clk) begin
        int_ready = 1'b0;
        if (rst_n) begin
            if (pend) begin
                if (wcnt == 0) begin
                    int_ready = 1'b1;
                    int_rdata = tmem[pend_addr];
                    pend = 0;
                end else wcnt--;
            end
            if (int_req) begin
                req_cnt++;
                if (int_we) tmem[int_addr[3:0]] = int_wdata;
                if (tgt_on) begin
                    pend_addr = int_addr[3:0];
                    wcnt = tgt_lat;
                    if (wcnt == 0) begin
                        int_ready = 1'b1;
                        int_rdata = tmem[pend_addr];
                    end else begin
                        pend = 1;
                        wcnt--;
                    end
                end
            end
        end
    end

    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, input bit c, input logic [31:0] e,
                           input string t, output logic [31:0] v);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        chk_q.push_back(c); exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        host_valid = 1'b0;
        @(negedge clk);
        #1 v = last_rd;
    endtask

    task automatic poll_done(output logic [31:0] v);
        v = '0;
        for (int i = 0; i < 40 && v == 0; i++) host_rd(3'd4, 0, 0, "poll", v);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base;
        for (int i = 0; i < 16; i++) tmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state of every location
        for (int i = 0; i < 6; i++) host_rd(3'(i), 1, 0, "R1 reset", v);

        // R1 readback
        host_wr(3'd0, 32'h0000_0005);
        host_wr(3'd1, 32'hA5A5_1234);
        host_rd(3'd0, 1, 32'h0000_0005, "R1 addr readback", v);
        host_rd(3'd1, 1, 32'hA5A5_1234, "R1 wdata readback", v);

        // R2 write access, R4 pending then done
        tgt_lat = 2;
        host_wr(3'd3, 32'h8000_0000);
        check("R2 req", {31'b0, int_req}, 1);
        check("R2 we", {31'b0, int_we}, 1);
        check("R2 addr", {16'b0, int_addr}, 32'h5);
        check("R2 wdata", int_wdata, 32'hA5A5_1234);
        host_rd(3'd4, 1, 0, "R4 pending", v);
        poll_done(v);
        check("R4 done", v, 1);
        check("R2 target written", tmem[5], 32'hA5A5_1234);
        check("R2 one request", req_cnt, 1);

        // R7 rewrite same command: no new access
        host_wr(3'd3, 32'h8000_0000);
        idle(5);
        check("R7 no retrigger", req_cnt, 1);
        // R5 clear done
        host_wr(3'd3, 32'h0);
        host_rd(3'd4, 1, 0, "R5 done cleared", v);

        // R3 read access
        tmem[9] = 32'hDEAD_BEEF;
        tgt_lat = 0;
        host_wr(3'd0, 32'h0000_0009);
        host_wr(3'd3, 32'h4000_0000);
        check("R3 req", {31'b0, int_req}, 1);
        check("R3 we low", {31'b0, int_we}, 0);
        poll_done(v);
        check("R3 done", v, 1);
        host_rd(3'd2, 1, 32'hDEAD_BEEF, "R3 rdata", v);
        host_wr(3'd3, 32'h0);
        host_rd(3'd2, 1, 32'hDEAD_BEEF, "R5 rdata kept", v);
        host_rd(3'd4, 1, 0, "R5 done cleared after read", v);

        // R10 read-only locations
        host_wr(3'd2, 32'h1111_1111);
        host_rd(3'd2, 1, 32'hDEAD_BEEF, "R10 rdata read-only", v);
        host_wr(3'd4, 32'h0000_0001);
        host_rd(3'd4, 1, 0, "R10 done read-only", v);

        // R6 both bits / no bit
        base = req_cnt;
        host_wr(3'd3, 32'hC000_0000);
        idle(5);
        check("R6 both bits", req_cnt, base);
        host_wr(3'd3, 32'h0000_0001);
        idle(5);
        check("R6 no bit", req_cnt, base);
        host_rd(3'd4, 1, 0, "R6 no done", v);
        host_wr(3'd3, 32'h0);

        // R8 timeout
        tgt_on = 0;
        host_wr(3'd0, 32'h0000_0003);
        host_wr(3'd3, 32'h8000_0000);
        idle(6);
        host_rd(3'd5, 1, 0, "R8 no error yet", v);
        idle(TOUT);
        host_rd(3'd5, 1, 1, "R8 error set", v);
        host_rd(3'd4, 1, 0, "R8 done stays low", v);
        tgt_on = 1;
        host_wr(3'd3, 32'h0);
        host_rd(3'd5, 1, 0, "R5 error cleared", v);

        // R9 commands while pending are ignored
        tmem[9] = 32'h0BAD_F00D;
        tgt_lat = 8;
        host_wr(3'd0, 32'h0000_0009);
        base = req_cnt;
        host_wr(3'd3, 32'h4000_0000);
        host_wr(3'd3, 32'h0);
        host_wr(3'd3, 32'h8000_0000);
        poll_done(v);
        check("R9 done", v, 1);
        idle(4);
        check("R9 single request", req_cnt, base + 1);
        host_rd(3'd2, 1, 32'h0BAD_F00D, "R9 read result", v);
        host_wr(3'd3, 32'h0);

        idle(3);
        check("R1 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule